// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a set of interrupt-requesting devices and a small CPU core. Every request line is captured into a sticky pending bit. The block then picks the most urgent pending level that is allowed to interrupt the handler now running, and raises a single request toward the CPU. When the CPU acknowledges, the block waits for the device to supply its vector. It then reports the dispatch to the CPU, marks the level as in service, saves the previous service level on a nesting stack, and makes the new level current. A return strobe from the CPU retires the current level and restores the one saved beneath it.

Levels have fixed priorities, and a lower index is more urgent. Level 0 is non-maskable. The top few levels belong to software, which raises them through a small set port. These software levels need no device vector, and their vector is the level number. If a device does not supply its vector within a programmable window after the acknowledge, the block raises a bus-error pulse instead of dispatching.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, cpu_req, disp_valid and bus_err are 0, svc_mask is all zero, and cur_lvl equals NUM_LVL, the idle value that ranks below every level.
- R2: A one-cycle pulse on irq_in[i] is latched at the first clock edge. When the level is eligible, cpu_req goes high after the second edge.
- R3: Priority is fixed and a lower index wins. When several eligible levels are pending, the dispatched level is the smallest index.
- R4: A pending level is eligible only when its index is strictly less than cur_lvl. A level that is not eligible stays pending and raises no request.
- R5: irq_mask[i]=1 blocks level i for i from 1 up, and the level stays pending until unmasked. Level 0 ignores its mask bit.
- R6: For a device level, a dev_vec_valid given within TIMEOUT cycles after the acknowledge produces one cycle of disp_valid. In that cycle disp_lvl is the level and disp_vec equals dev_vec. The svc_mask bit of that level is set, cur_lvl becomes the level, and cpu_req is low in the cycle after the acknowledge.
- R7: When no vector arrives, bus_err pulses for one cycle after the TIMEOUT-th edge following the acknowledge edge. No dispatch happens, the level is dropped, and cur_lvl and svc_mask are unchanged.
- R8: cpu_ret clears the svc_mask bit of cur_lvl and restores the previous cur_lvl. A request held back by R4 is then raised one edge later.
- R9: sw_set_valid with sw_set_lvl at or above NUM_LVL-SW_CNT sets that pending bit. A write that names a lower level is ignored.
- R10: A software level dispatches on the edge after its acknowledge without a device vector, and disp_vec equals the level number.
- R11: cpu_ack while cpu_req is low, and cpu_ret while nothing is in service, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LVL | Device request lines, bit 0 non-maskable |
| irq_mask | input | NUM_LVL | Per-level block, bit 0 ignored |
| sw_set_valid | input | 1 | Software raise strobe |
| sw_set_lvl | input | IDXW | Level named by the software raise |
| cpu_req | output | 1 | Interrupt request to the CPU |
| cpu_ack | input | 1 | CPU acknowledge |
| dev_vec_valid | input | 1 | Device vector present |
| dev_vec | input | VEC_W | Device vector |
| disp_valid | output | 1 | Dispatch pulse |
| disp_lvl | output | IDXW | Level dispatched |
| disp_vec | output | VEC_W | Vector index dispatched |
| bus_err | output | 1 | Vector timeout pulse |
| cpu_ret | input | 1 | Handler return strobe |
| svc_mask | output | NUM_LVL | In-service latch bits |
| cur_lvl | output | LW | Current service level, NUM_LVL when idle |

## Verification
A request reaches cpu_req two edges after its pulse: one edge to latch it and one to recognise it. A device dispatch shows one edge after the vector. A software dispatch shows one edge after the acknowledge. A timeout shows exactly TIMEOUT edges after the acknowledge. A return updates cur_lvl after one edge, and a held request appears one edge after that. The bench drives inputs and samples outputs on falling edges only, and steps a counted number of rising edges before each check. It also checks the value one edge early where a result must not yet be visible.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } vic_st_e;
endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
    parameter int NUM_LVL = 8,
    localparam int IDXW = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] elig,
    output logic               valid,
    output logic [IDXW-1:0]    idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (elig[i]) begin
                valid = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
    parameter int DEPTH = 8,
    parameter int W = 4,
    localparam int SPW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty
);
    typedef struct packed {
        logic [SPW-1:0]            sp;
        logic [DEPTH-1:0][W-1:0]   mem;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        top   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (stk_q.sp == SPW'(i + 1)) top = stk_q.mem[i];
        end
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (stk_q.sp == SPW'(i)) stk_d.mem[i] = din;
            end
            stk_d.sp = stk_q.sp + 1'b1;
        end else if (pop) begin
            stk_d.sp = stk_q.sp - 1'b1;
        end
    end

    assign empty = (stk_q.sp == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (stk_q.sp < SPW'(DEPTH)));
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_push_pop_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/vic_vec_timer.sv
module vic_vec_timer #(
    parameter int TIMEOUT = 16,
    localparam int CW = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = en && (cnt_q == CW'(TIMEOUT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                cnt_d = '0;
        else if (en && !expired) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_LVL = 8,
    parameter int SW_CNT  = 2,
    parameter int VEC_W   = 8,
    parameter int TIMEOUT = 16,
    localparam int IDXW = $clog2(NUM_LVL),
    localparam int LW   = $clog2(NUM_LVL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] irq_in,
    input  logic [NUM_LVL-1:0] irq_mask,
    input  logic               sw_set_valid,
    input  logic [IDXW-1:0]    sw_set_lvl,
    output logic               cpu_req,
    input  logic               cpu_ack,
    input  logic               dev_vec_valid,
    input  logic [VEC_W-1:0]   dev_vec,
    output logic               disp_valid,
    output logic [IDXW-1:0]    disp_lvl,
    output logic [VEC_W-1:0]   disp_vec,
    output logic               bus_err,
    input  logic               cpu_ret,
    output logic [NUM_LVL-1:0] svc_mask,
    output logic [LW-1:0]      cur_lvl
);
    localparam logic [IDXW-1:0] SW_BASE = IDXW'(NUM_LVL - SW_CNT);

    typedef struct packed {
        vic_st_e            st;
        logic [NUM_LVL-1:0] pend;
        logic [NUM_LVL-1:0] svc;
        logic [LW-1:0]      cur;
        logic [IDXW-1:0]    sel;
        logic               req;
        logic               disp;
        logic [IDXW-1:0]    dlvl;
        logic [VEC_W-1:0]   dvec;
        logic               berr;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NUM_LVL-1:0] elig;
    logic [NUM_LVL-1:0] set_bits;
    logic [NUM_LVL-1:0] clr_bits;
    logic               cand_v;
    logic [IDXW-1:0]    cand_idx;
    logic               stk_push, stk_pop, stk_empty;
    logic [LW-1:0]      stk_top;
    logic               tmr_clr, tmr_exp;
    logic               ack_ok;

    // Eligibility per level: pending, unmasked (level 0 never masked), above current
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_elig
        if (g == 0) begin : g_nmi
            assign elig[g] = c_q.pend[g] && (LW'(g) < c_q.cur);
        end else begin : g_mask
            assign elig[g] = c_q.pend[g] && !irq_mask[g] && (LW'(g) < c_q.cur);
        end
    end

    vic_prio_pick #(.NUM_LVL(NUM_LVL)) u_pick (
        .elig  (elig),
        .valid (cand_v),
        .idx   (cand_idx)
    );

    vic_nest_stack #(.DEPTH(NUM_LVL), .W(LW)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (c_q.cur),
        .top   (stk_top),
        .empty (stk_empty)
    );

    vic_vec_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .en      (c_q.st == ST_WAIT),
        .expired (tmr_exp)
    );

    assign ack_ok = (c_q.st == ST_IDLE) && cpu_ack && c_q.req && cand_v;

    always_comb begin
        c_d      = c_q;
        c_d.disp = 1'b0;
        c_d.berr = 1'b0;
        set_bits = irq_in;
        clr_bits = '0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        tmr_clr  = 1'b0;

        if (sw_set_valid && (sw_set_lvl >= SW_BASE)) set_bits[sw_set_lvl] = 1'b1;

        case (c_q.st)
            ST_IDLE: begin
                if (ack_ok) begin
                    clr_bits[cand_idx] = 1'b1;
                    c_d.sel = cand_idx;
                    c_d.st  = ST_WAIT;
                    tmr_clr = 1'b1;
                end else if (cpu_ret && !stk_empty) begin
                    c_d.svc[c_q.cur[IDXW-1:0]] = 1'b0;
                    c_d.cur = stk_top;
                    stk_pop = 1'b1;
                end
            end
            ST_WAIT: begin
                if ((c_q.sel >= SW_BASE) || dev_vec_valid) begin
                    c_d.disp = 1'b1;
                    c_d.dlvl = c_q.sel;
                    c_d.dvec = (c_q.sel >= SW_BASE) ? VEC_W'(c_q.sel) : dev_vec;
                    c_d.svc[c_q.sel] = 1'b1;
                    c_d.cur = LW'(c_q.sel);
                    stk_push = 1'b1;
                    c_d.st = ST_IDLE;
                end else if (tmr_exp) begin
                    c_d.berr = 1'b1;
                    c_d.st   = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase

        c_d.pend = (c_q.pend & ~clr_bits) | set_bits;
        c_d.req  = (c_q.st == ST_IDLE) && cand_v && !ack_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.st  <= ST_IDLE;
            c_q.cur <= LW'(NUM_LVL);
        end else begin
            c_q <= c_d;
        end
    end

    assign cpu_req    = c_q.req;
    assign disp_valid = c_q.disp;
    assign disp_lvl   = c_q.dlvl;
    assign disp_vec   = c_q.dvec;
    assign bus_err    = c_q.berr;
    assign svc_mask   = c_q.svc;
    assign cur_lvl    = c_q.cur;

    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack) |=> !cpu_req);
    p_disp_cur_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (cur_lvl == LW'(disp_lvl) && svc_mask[disp_lvl]));
    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_valid && bus_err));
    p_berr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);
    p_sw_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_lvl >= SW_BASE) |-> (disp_vec == VEC_W'(disp_lvl)));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    localparam int N = 8;
    localparam int IDXW = 3;
    localparam int LW = 4;
    localparam int VW = 8;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] irq_in = '0, irq_mask = '0;
    logic sw_set_valid = 1'b0;
    logic [IDXW-1:0] sw_set_lvl = '0;
    logic cpu_req, cpu_ack = 1'b0, dev_vec_valid = 1'b0;
    logic [VW-1:0] dev_vec = '0;
    logic disp_valid, bus_err, cpu_ret = 1'b0;
    logic [IDXW-1:0] disp_lvl;
    logic [VW-1:0] disp_vec;
    logic [N-1:0] svc_mask;
    logic [LW-1:0] cur_lvl;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_mask(irq_mask),
        .sw_set_valid(sw_set_valid), .sw_set_lvl(sw_set_lvl), .cpu_req(cpu_req),
        .cpu_ack(cpu_ack), .dev_vec_valid(dev_vec_valid), .dev_vec(dev_vec),
        .disp_valid(disp_valid), .disp_lvl(disp_lvl), .disp_vec(disp_vec),
        .bus_err(bus_err), .cpu_ret(cpu_ret), .svc_mask(svc_mask), .cur_lvl(cur_lvl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int lvl);
        irq_in[lvl] = 1'b1; step(); irq_in = '0;
    endtask

    task automatic ack();
        cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
    endtask

    task automatic vec(input int v);
        dev_vec_valid = 1'b1; dev_vec = VW'(v); step();
        dev_vec_valid = 1'b0; dev_vec = '0;
    endtask

    task automatic ret();
        cpu_ret = 1'b1; step(); cpu_ret = 1'b0;
    endtask

    task automatic serve(input int lvl, input int v, input string tag);
        pulse(lvl); step(); chk({tag, " req"}, cpu_req, 1);
        ack(); chk({tag, " req drop"}, cpu_req, 0);
        vec(v);
        chk({tag, " disp"}, disp_valid, 1);
        chk({tag, " lvl"}, disp_lvl, lvl);
        chk({tag, " vec"}, disp_vec, v);
        chk({tag, " cur"}, cur_lvl, lvl);
        step(); chk({tag, " disp pulse"}, disp_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1 req", cpu_req, 0);
        chk("R1 disp", disp_valid, 0);
        chk("R1 berr", bus_err, 0);
        chk("R1 svc", svc_mask, 0);
        chk("R1 cur", cur_lvl, N);
    endtask

    task automatic t_latency();
        pulse(4); chk("R2 req early", cpu_req, 0);
        step(); chk("R2 req", cpu_req, 1);
        ack(); vec(8'h44);
        chk("R6 disp", disp_valid, 1);
        chk("R6 vec", disp_vec, 8'h44);
        chk("R6 svc", svc_mask, 8'h10);
        step(); ret();
        chk("R8 cur idle", cur_lvl, N);
        chk("R8 svc clear", svc_mask, 0);
    endtask

    task automatic t_priority();
        irq_in = 8'b0001_0100; step(); irq_in = '0; step();
        ack(); vec(8'h22);
        chk("R3 winner", disp_lvl, 2);
        step(); ret(); step();
        chk("R3 next req", cpu_req, 1);
        ack(); vec(8'h40);
        chk("R3 second", disp_lvl, 4);
        step(); ret();
    endtask

    task automatic t_nesting();
        serve(3, 8'h33, "R6 lvl3");
        pulse(5); step(3);
        chk("R4 lower held", cpu_req, 0);
        serve(1, 8'h11, "R4 nest");
        chk("R4 svc both", svc_mask, 8'h0A);
        ret();
        chk("R8 restore", cur_lvl, 3);
        chk("R8 svc", svc_mask, 8'h08);
        step(); chk("R8 still held", cpu_req, 0);
        ret();
        chk("R8 idle", cur_lvl, N);
        chk("R8 req same edge", cpu_req, 0);
        step(); chk("R8 held raised", cpu_req, 1);
        ack(); vec(8'h55);
        chk("R8 held lvl", disp_lvl, 5);
        step(); ret();
    endtask

    task automatic t_mask();
        irq_mask = 8'hFF;
        pulse(1); step(3);
        chk("R5 masked", cpu_req, 0);
        irq_mask = 8'hFD; step();
        chk("R5 unmask", cpu_req, 1);
        irq_mask = 8'hFF; step();
        chk("R5 remask", cpu_req, 0);
        serve(0, 8'h0E, "R5 nmi");
        irq_mask = 8'h00; step();
        chk("R5 level1 below nmi", cpu_req, 0);
        ret(); step();
        chk("R5 level1 after", cpu_req, 1);
        ack(); vec(8'h01);
        chk("R5 level1 lvl", disp_lvl, 1);
        step(); ret();
    endtask

    task automatic t_timeout();
        pulse(2); step(); ack();
        step(TO - 1);
        chk("R7 berr early", bus_err, 0);
        step();
        chk("R7 berr", bus_err, 1);
        chk("R7 no disp", disp_valid, 0);
        step();
        chk("R7 pulse", bus_err, 0);
        chk("R7 cur", cur_lvl, N);
        chk("R7 svc", svc_mask, 0);
        chk("R7 dropped", cpu_req, 0);
    endtask

    task automatic t_software();
        sw_set_valid = 1'b1; sw_set_lvl = 3'd3; step(); sw_set_valid = 1'b0;
        step(2); chk("R9 ignored", cpu_req, 0);
        sw_set_valid = 1'b1; sw_set_lvl = 3'd7; step(); sw_set_valid = 1'b0;
        step(); chk("R9 sw req", cpu_req, 1);
        ack(); step();
        chk("R10 disp", disp_valid, 1);
        chk("R10 lvl", disp_lvl, 7);
        chk("R10 vec", disp_vec, 7);
        step(); ret();
        chk("R10 idle", cur_lvl, N);
    endtask

    task automatic t_spurious();
        ack(); step();
        chk("R11 ack ignored req", cpu_req, 0);
        chk("R11 ack ignored disp", disp_valid, 0);
        ret();
        chk("R11 ret cur", cur_lvl, N);
        chk("R11 ret svc", svc_mask, 0);
        serve(6, 8'h06, "R11 after");
        ret();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_latency();
        t_priority();
        t_nesting();
        t_mask();
        t_timeout();
        t_software();
        t_spurious();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule